// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

The block drives a processor reset from two causes. The first is a digital supply-valid flag. While that flag is low the reset is held, and this includes power-up. When the flag goes high, the reset is released only after a fixed hold interval. The second cause is a watchdog on the chip-select line. When the watchdog is enabled and chip-select stays at one level for longer than the selected timeout, the block raises reset again. A watchdog reset is held for the same hold interval.

All time constants are counted in prescaled ticks. A free-running prescaler produces one tick every `PRESCALE` clocks. The hold length and the three watchdog periods are parameters, so simulation can run with short values. Chip-select is synchronised by two flops, and only its high-to-low edge restarts the watchdog. The reset is provided in both polarities.

Top module: `supply_supervisor`

## Requirements
- R1: While `supplyOk` is low, `rstOutN` is 0 and `rstOut` is 1 at once, without waiting for a clock edge. This also holds at power-up.
- R2: After `supplyOk` rises, the reset stays asserted through clock edge HOLD_TICKS*PRESCALE and is released at edge HOLD_TICKS*PRESCALE+1. Edges are counted from the first rising clock edge after the rise of `supplyOk`.
- R3: `rstOut` is always the exact complement of `rstOutN`.
- R4: `wdSel` chooses the watchdog period: 00 selects WD_TICKS0, 01 selects WD_TICKS1 and 10 selects WD_TICKS2. Take W as the selected period. If chip-select has no falling edge while the block is out of reset, the reset reasserts W*PRESCALE edges after its release. This holds whether chip-select is static high or static low.
- R5: `wdSel` = 11 disables the watchdog, and the reset then never reasserts while the supply is valid.
- R6: A falling edge of `csN` restarts the watchdog count after a two-flop synchroniser. Let a be the edge just before `csN` falls, and let T1 be the first tick edge (a multiple of PRESCALE) greater than a+3. The reset then reasserts at edge T1+(W-1)*PRESCALE+1.
- R7: A rising edge of `csN` does not restart the watchdog count.
- R8: A watchdog-triggered reset is held for HOLD_TICKS ticks and is released at edge (2*HOLD_TICKS+W)*PRESCALE+1. The watchdog count restarts at that release, so with no kick the next reset comes at edge (2*HOLD_TICKS+2*W)*PRESCALE+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| supplyOk | input | 1 | High when the supply is above its trip level. Low asserts reset asynchronously |
| csN | input | 1 | Monitored chip-select, active low, asynchronous to `clk` |
| wdSel | input | 2 | Watchdog period select; 11 disables the watchdog |
| rstOutN | output | 1 | Reset, active low |
| rstOut | output | 1 | Reset, active high |

## Verification
The bench sweeps every enabled period code with chip-select held static high and with it held static low. This shows that the timeout does not depend on the level at which chip-select is stuck. Each of these runs checks the exact edges of release, watchdog reassertion, the second release and the second timeout. Together they separate the hold length, the period decode and the restart of the count. A run with the disable code confirms that the watchdog is off.

A run with periodic kicks checks that falling edges keep the reset released. Its last kick is followed by a rising edge, and the expected reassertion edge is computed from the fall alone. This run therefore exposes any error in the synchroniser latency or any restart on the wrong edge.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;

  typedef struct packed {
    logic holdClr;
    logic wdClr;
  } supCtl_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;

endpackage

// File: rtl/supervisor_datapath.sv
module supervisor_datapath
  import supervisor_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int HOLD_TICKS = 20,
  parameter int WD_TICKS0  = 10,
  parameter int WD_TICKS1  = 25,
  parameter int WD_TICKS2  = 50
) (
  input  logic    clk,
  input  logic    supplyOk,
  input  logic    csN,
  input  logic [1:0] wdSel,
  input  supCtl_t ctl,
  output logic    holdDone,
  output logic    wdExpired
);

  localparam int WD_MAX01 = (WD_TICKS0 > WD_TICKS1) ? WD_TICKS0 : WD_TICKS1;
  localparam int WD_MAX   = (WD_MAX01 > WD_TICKS2) ? WD_MAX01 : WD_TICKS2;
  localparam int HW       = $clog2(HOLD_TICKS + 1);
  localparam int WW       = $clog2(WD_MAX + 1);

  logic tick;

  // prescaler: variant picked by parameter
  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk or negedge supplyOk) begin
        if (!supplyOk) preCnt <= '0;
        else if (preCnt == PW'(PRESCALE - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PW'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // two-flop synchroniser plus edge history
  logic [1:0] csSync;
  logic       csPrev;
  logic       csFall;
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      csSync <= 2'b11;
      csPrev <= 1'b1;
    end else begin
      csSync <= {csSync[0], csN};
      csPrev <= csSync[1];
    end
  end
  assign csFall = csPrev & ~csSync[1];

  // hold interval counter
  logic [HW-1:0] holdCnt;
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) holdCnt <= '0;
    else if (ctl.holdClr) holdCnt <= '0;
    else if (tick && !holdDone) holdCnt <= holdCnt + 1'b1;
  end
  assign holdDone = (holdCnt == HW'(HOLD_TICKS));

  // watchdog counter
  logic [WW-1:0] wdCnt;
  logic [WW-1:0] wdLimit;
  logic          wdOn;
  always_comb begin
    wdOn = 1'b1;
    case (wdSel)
      2'b00:   wdLimit = WW'(WD_TICKS0);
      2'b01:   wdLimit = WW'(WD_TICKS1);
      2'b10:   wdLimit = WW'(WD_TICKS2);
      default: begin
        wdLimit = WW'(WD_MAX);
        wdOn    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) wdCnt <= '0;
    else if (ctl.wdClr || csFall) wdCnt <= '0;
    else if (tick && (wdCnt < WW'(WD_MAX))) wdCnt <= wdCnt + 1'b1;
  end
  assign wdExpired = wdOn && (wdCnt >= wdLimit);

  // R5
  wd_off_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    (wdSel == 2'b11) |-> !wdExpired);

  // R6
  kick_clear_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    csFall |=> (wdCnt == '0));

  // R4
  wd_sat_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    wdCnt <= WW'(WD_MAX));

endmodule

// File: rtl/supervisor_control.sv
module supervisor_control
  import supervisor_pkg::*;
(
  input  logic    clk,
  input  logic    supplyOk,
  input  logic    holdDone,
  input  logic    wdExpired,
  output supCtl_t ctl,
  output logic    rstActive
);

  supState_t state;

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) state <= ST_HOLD;
    else begin
      case (state)
        ST_HOLD: if (holdDone) state <= ST_RUN;
        ST_RUN:  if (wdExpired) state <= ST_HOLD;
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    ctl.holdClr = (state == ST_RUN);
    ctl.wdClr   = (state == ST_HOLD);
  end

  assign rstActive = (state == ST_HOLD);

  // R1
  supply_low_chk: assert property (@(posedge clk)
    !supplyOk |-> rstActive);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    $fell(rstActive) |-> $past(holdDone));

  // R4
  wd_fire_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    (!rstActive && wdExpired) |=> rstActive);

  // R8
  hold_restart_chk: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(rstActive) |-> !holdDone);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supervisor_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int HOLD_TICKS = 20,
  parameter int WD_TICKS0  = 10,
  parameter int WD_TICKS1  = 25,
  parameter int WD_TICKS2  = 50
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       csN,
  input  logic [1:0] wdSel,
  output logic       rstOutN,
  output logic       rstOut
);

  supCtl_t ctl;
  logic    holdDone;
  logic    wdExpired;
  logic    rstActive;

  supervisor_datapath #(
    .PRESCALE  (PRESCALE),
    .HOLD_TICKS(HOLD_TICKS),
    .WD_TICKS0 (WD_TICKS0),
    .WD_TICKS1 (WD_TICKS1),
    .WD_TICKS2 (WD_TICKS2)
  ) u_dp (
    .clk      (clk),
    .supplyOk (supplyOk),
    .csN      (csN),
    .wdSel    (wdSel),
    .ctl      (ctl),
    .holdDone (holdDone),
    .wdExpired(wdExpired)
  );

  supervisor_control u_ctl (
    .clk      (clk),
    .supplyOk (supplyOk),
    .holdDone (holdDone),
    .wdExpired(wdExpired),
    .ctl      (ctl),
    .rstActive(rstActive)
  );

  assign rstOut  = rstActive;
  assign rstOutN = ~rstActive;

endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int H  = 20;
  localparam int W0 = 10;
  localparam int W1 = 25;
  localparam int W2 = 50;

  logic       clk = 1'b0;
  logic       supplyOk = 1'b0;
  logic       csN = 1'b1;
  logic [1:0] wdSel = 2'b00;
  logic       rstOutN;
  logic       rstOut;

  int checks = 0;
  int fails  = 0;
  int e      = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_supervisor #(
    .PRESCALE(P), .HOLD_TICKS(H),
    .WD_TICKS0(W0), .WD_TICKS1(W1), .WD_TICKS2(W2)
  ) uut (
    .clk(clk), .supplyOk(supplyOk), .csN(csN), .wdSel(wdSel),
    .rstOutN(rstOutN), .rstOut(rstOut)
  );

  // both polarities compared every time (R3)
  task automatic chk(input string req, input bit expActive);
    checks++;
    if (rstOut !== expActive || rstOutN !== ~expActive) begin
      fails++;
      $display("FAIL %s at edge %0d: rstOut=%b rstOutN=%b expected rstOut=%b rstOutN=%b",
               req, e, rstOut, rstOutN, expActive, ~expActive);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    e += n;
  endtask

  task automatic stepTo(input int target);
    if (target > e) step(target - e);
  endtask

  function automatic int wdOf(input int s);
    return (s == 0) ? W0 : (s == 1) ? W1 : W2;
  endfunction

  task automatic powerCycle(input logic csLevel, input logic [1:0] sel);
    @(negedge clk);
    supplyOk = 1'b0;
    csN   = csLevel;
    wdSel = sel;
    #1 chk("R1", 1'b1);
    step(3);
    chk("R1", 1'b1);
    supplyOk = 1'b1;
    e = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1 chk("R1", 1'b1);

    // static chip-select, every enabled period, both levels
    for (int s = 0; s < 3; s++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        int w;
        w = wdOf(s);
        powerCycle(lvl[0], 2'(s));
        stepTo(H * P);               chk("R2", 1'b1);
        stepTo(H * P + 1);           chk("R2", 1'b0);
        stepTo((H + w) * P);         chk("R4", 1'b0);
        stepTo((H + w) * P + 1);     chk("R4", 1'b1);
        stepTo((2 * H + w) * P);     chk("R8", 1'b1);
        stepTo((2 * H + w) * P + 1); chk("R8", 1'b0);
        stepTo((2 * H + 2 * w) * P);     chk("R8", 1'b0);
        stepTo((2 * H + 2 * w) * P + 1); chk("R8", 1'b1);
      end
    end

    // disabled watchdog
    begin
      bit bad;
      bad = 1'b0;
      powerCycle(1'b1, 2'b11);
      stepTo(H * P + 1);
      chk("R5", 1'b0);
      for (int i = 0; i < 500; i++) begin
        step(1);
        if (rstOut !== 1'b0) bad = 1'b1;
      end
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL R5: reset reasserted, actual=1 expected=0");
      end
    end

    // kicks by falling edges, then a rise that must not restart
    begin
      int a;
      int t1;
      int expEdge;
      bit bad;
      bad = 1'b0;
      powerCycle(1'b1, 2'b00);
      stepTo(H * P + 1);
      chk("R2", 1'b0);
      for (int k = 0; k < 3; k++) begin
        stepTo(100 + 30 * k);
        csN = 1'b0;
        stepTo(105 + 30 * k);
        csN = 1'b1;
      end
      stepTo(190);
      csN = 1'b0;
      a = 190;
      stepTo(210);
      csN = 1'b1;
      t1 = ((a + 3) / P + 1) * P;
      expEdge = t1 + (W0 - 1) * P + 1;
      // released throughout the kicked stretch
      for (int i = e; i < expEdge - 1; i++) begin
        step(1);
        if (rstOut !== 1'b0) bad = 1'b1;
      end
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL R6: reset during kicks, actual=1 expected=0");
      end
      chk("R7", 1'b0);
      stepTo(expEdge);
      chk("R6", 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule